// File: doc/BRIEF.md
# Four-Way Translation Buffer Lookup with Access Protection

This block holds a small set-associative cache of address translations: sixteen rows, each with four ways, covering 8 KB pages. Software loads an entry by giving the way, the row and two 32-bit words. The tag word carries the virtual page number in bits 31:13 and an 8-bit process tag in bits 7:0. The attribute word carries the physical frame number in bits 31:13, plus four flags: shared-by-all-processes (bit 4), present (bit 3), supervisor-only (bit 2) and writable (bit 1).

Each lookup request takes a 32-bit virtual address, the running process tag, a user-mode flag, a read/write flag and two configuration inputs. The row is chosen from the low four bits of the page number, and all four ways of that row are compared at the same time. The registered result gives a hit flag, the way that matched, the physical address, a fault code and the matched entry's two words, which software can read back. When translation is switched off, the address passes through unchanged. Picking a victim way, walking page tables and raising exceptions belong to other blocks.

Top module: `tlb_lookup_top`

## Requirements
- R1: During and after synchronous reset, `res_valid` is 0, `res_fault` is 0, and every stored word is 0. A later lookup of any page other than page 0 therefore misses.
- R2: A write with `wr_en` high stores `wr_hi`/`wr_lo` at (`wr_way`, `wr_idx`). Lookups from the next cycle on see the new entry. A lookup presented in the same cycle as the write sees the old contents.
- R3: The row looked up is `lk_vaddr[16:13]`. A way matches only when its full 19-bit page number equals `lk_vaddr[31:13]`.
- R4: A way matches only if its shared flag (attribute bit 4) is set or its tag bits 7:0 equal `lk_pid`. When translation is on and no way matches, the result is `res_hit`=0 with fault code 1 (miss), `res_paddr`=0 and `res_way`=0.
- R5: If several ways match, the lowest-numbered way is reported.
- R6: For a hit with fault code 0, `res_paddr` is the frame number (attribute bits 31:13) followed by `lk_vaddr[12:0]`.
- R7: For a hit on an entry whose present flag (bit 3) is clear, the fault code is 2. This takes priority over every other fault.
- R8: For a hit with `cfg_kguard`=1, `lk_user`=1 and the supervisor-only flag (bit 2) set, the fault code is 3. If `cfg_kguard` is 0 or `lk_user` is 0, this fault never occurs.
- R9: For a hit where `lk_write`=1 and the writable flag (bit 1) is clear, the fault code is 4, unless code 2 or 3 applies. A read never yields code 4.
- R10: With `cfg_mode`=0, translation is off: `res_hit`=0, `res_fault`=0, `res_paddr`=`lk_vaddr`, and `res_hi`/`res_lo` are 0.
- R11: On a hit, whether or not it faults, `res_hi`/`res_lo` are the matched entry's words and `res_paddr` is 0 if the fault code is nonzero. On no hit, `res_hi`/`res_lo` are 0.
- R12: Results are registered. `res_valid` is high in exactly the cycle after a cycle with `lk_valid` high, and the result fields hold their values between lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry write strobe |
| wr_way | input | 2 | Way to write |
| wr_idx | input | 4 | Row to write |
| wr_hi | input | 32 | Tag word to store |
| wr_lo | input | 32 | Attribute word to store |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_pid | input | 8 | Current process tag |
| lk_user | input | 1 | Access from user mode |
| lk_write | input | 1 | Access is a write |
| cfg_mode | input | 2 | Translation on when nonzero |
| cfg_kguard | input | 1 | Enables supervisor-only protection |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | A way matched |
| res_way | output | 2 | Matched way |
| res_paddr | output | 32 | Physical address |
| res_fault | output | 3 | 0 none, 1 miss, 2 not present, 3 supervisor-only, 4 write-protect |
| res_hi | output | 32 | Matched tag word |
| res_lo | output | 32 | Matched attribute word |

## Verification
The bench builds the block with its default four ways and sixteen rows. This is small enough that random page numbers drawn from a pool of three per row often put the same page in more than one way, which exercises the lowest-way priority. A reference model of all 64 entries in the bench predicts every field, and process tags drawn from 0 to 3 make tag hits, tag misses and shared-entry hits all common. Directed cases cover the fault priority order, passthrough mode and a write in the same cycle as a lookup.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 13;
    localparam int VPN_W      = VA_W - PAGE_SHIFT;
    localparam int PID_W      = 8;

    // attribute word flag positions
    localparam int LO_WR_BIT   = 1;
    localparam int LO_KERN_BIT = 2;
    localparam int LO_PRES_BIT = 3;
    localparam int LO_SHR_BIT  = 4;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_MISS    = 3'd1,
        FLT_ABSENT  = 3'd2,
        FLT_KERNEL  = 3'd3,
        FLT_WPROT   = 3'd4
    } fault_e;

    typedef struct packed {
        logic shared;
        logic present;
        logic kern;
        logic wr_ok;
    } perm_t;

    typedef struct packed {
        logic            hit;
        fault_e          fault;
        logic [VA_W-1:0] paddr;
        logic [VA_W-1:0] hi;
        logic [VA_W-1:0] lo;
    } xlat_t;

    // flags is attribute word bits [4:1]
    function automatic perm_t unpack_perm(input logic [3:0] flags);
        perm_t p;
        p.shared  = flags[LO_SHR_BIT-1];
        p.present = flags[LO_PRES_BIT-1];
        p.kern    = flags[LO_KERN_BIT-1];
        p.wr_ok   = flags[LO_WR_BIT-1];
        return p;
    endfunction

    function automatic fault_e judge_access(input perm_t p, input logic user,
                                            input logic wr, input logic kguard);
        if (!p.present)
            return FLT_ABSENT;
        else if (kguard && p.kern && user)
            return FLT_KERNEL;
        else if (wr && !p.wr_ok)
            return FLT_WPROT;
        return FLT_NONE;
    endfunction

endpackage

// File: rtl/tlb_way_store.sv
module tlb_way_store #(
    parameter int ROWS  = 16,
    parameter int WORD  = 32,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WORD-1:0]  wr_hi,
    input  logic [WORD-1:0]  wr_lo,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WORD-1:0]  rd_hi,
    output logic [WORD-1:0]  rd_lo
);

    logic [WORD-1:0] hi_q [ROWS];
    logic [WORD-1:0] lo_q [ROWS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) begin
                hi_q[r] <= '0;
                lo_q[r] <= '0;
            end
        end else if (wr_en) begin
            hi_q[wr_idx] <= wr_hi;
            lo_q[wr_idx] <= wr_lo;
        end
    end

    assign rd_hi = hi_q[rd_idx];
    assign rd_lo = lo_q[rd_idx];

endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match #(
    parameter int VPN_W = 19,
    parameter int PID_W = 8
) (
    input  logic [VPN_W-1:0] ent_vpn,
    input  logic [PID_W-1:0] ent_pid,
    input  logic             ent_shared,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [PID_W-1:0] req_pid,
    output logic             match
);

    logic vpn_eq;
    logic owner_ok;

    assign vpn_eq   = (ent_vpn == req_vpn);
    assign owner_ok = ent_shared || (ent_pid == req_pid);
    assign match    = vpn_eq && owner_ok;

endmodule

// File: rtl/tlb_way_select.sv
module tlb_way_select #(
    parameter int WAYS  = 4,
    parameter int WORD  = 32,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]           match_vec,
    input  logic [WAYS-1:0][WORD-1:0] hi_words,
    input  logic [WAYS-1:0][WORD-1:0] lo_words,
    output logic                      sel_hit,
    output logic [WAY_W-1:0]          sel_way,
    output logic [WORD-1:0]           sel_hi,
    output logic [WORD-1:0]           sel_lo
);

    // walk downward so the lowest matching way is the last assignment
    always_comb begin
        sel_hit = 1'b0;
        sel_way = '0;
        sel_hi  = '0;
        sel_lo  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_vec[w]) begin
                sel_hit = 1'b1;
                sel_way = WAY_W'(w);
                sel_hi  = hi_words[w];
                sel_lo  = lo_words[w];
            end
        end
    end

endmodule

// File: rtl/tlb_lookup_top.sv
module tlb_lookup_top
    import tlb_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int ROWS  = 16,
    localparam int IDX_W = $clog2(ROWS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VA_W-1:0]  wr_hi,
    input  logic [VA_W-1:0]  wr_lo,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [PID_W-1:0] lk_pid,
    input  logic             lk_user,
    input  logic             lk_write,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_kguard,
    output logic             res_valid,
    output logic             res_hit,
    output logic [WAY_W-1:0] res_way,
    output logic [VA_W-1:0]  res_paddr,
    output logic [2:0]       res_fault,
    output logic [VA_W-1:0]  res_hi,
    output logic [VA_W-1:0]  res_lo
);

    logic [IDX_W-1:0]             row;
    logic [VPN_W-1:0]             req_vpn;
    logic [WAYS-1:0]              match_vec;
    logic [WAYS-1:0][VA_W-1:0]    way_hi;
    logic [WAYS-1:0][VA_W-1:0]    way_lo;
    logic                         sel_hit;
    logic [WAY_W-1:0]             sel_way;
    logic [VA_W-1:0]              sel_hi;
    logic [VA_W-1:0]              sel_lo;
    xlat_t                        nxt;
    logic [WAY_W-1:0]             nxt_way;

    assign row     = lk_vaddr[PAGE_SHIFT +: IDX_W];
    assign req_vpn = lk_vaddr[VA_W-1:PAGE_SHIFT];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic way_wr;
        assign way_wr = wr_en && (wr_way == WAY_W'(w));

        tlb_way_store #(.ROWS(ROWS), .WORD(VA_W)) store_i (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (way_wr),
            .wr_idx (wr_idx),
            .wr_hi  (wr_hi),
            .wr_lo  (wr_lo),
            .rd_idx (row),
            .rd_hi  (way_hi[w]),
            .rd_lo  (way_lo[w])
        );

        tlb_way_match #(.VPN_W(VPN_W), .PID_W(PID_W)) match_i (
            .ent_vpn    (way_hi[w][VA_W-1:PAGE_SHIFT]),
            .ent_pid    (way_hi[w][PID_W-1:0]),
            .ent_shared (way_lo[w][LO_SHR_BIT]),
            .req_vpn    (req_vpn),
            .req_pid    (lk_pid),
            .match      (match_vec[w])
        );
    end

    tlb_way_select #(.WAYS(WAYS), .WORD(VA_W)) select_i (
        .match_vec (match_vec),
        .hi_words  (way_hi),
        .lo_words  (way_lo),
        .sel_hit   (sel_hit),
        .sel_way   (sel_way),
        .sel_hi    (sel_hi),
        .sel_lo    (sel_lo)
    );

    always_comb begin
        nxt       = '0;
        nxt.fault = FLT_NONE;
        nxt_way   = '0;
        if (cfg_mode == 2'b00) begin
            nxt.paddr = lk_vaddr;
        end else if (!sel_hit) begin
            nxt.fault = FLT_MISS;
        end else begin
            nxt.hit   = 1'b1;
            nxt_way   = sel_way;
            nxt.hi    = sel_hi;
            nxt.lo    = sel_lo;
            nxt.fault = judge_access(unpack_perm(sel_lo[LO_SHR_BIT:LO_WR_BIT]),
                                     lk_user, lk_write, cfg_kguard);
            if (nxt.fault == FLT_NONE)
                nxt.paddr = {sel_lo[VA_W-1:PAGE_SHIFT], lk_vaddr[PAGE_SHIFT-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_way   <= '0;
            res_paddr <= '0;
            res_fault <= FLT_NONE;
            res_hi    <= '0;
            res_lo    <= '0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                res_hit   <= nxt.hit;
                res_way   <= nxt_way;
                res_paddr <= nxt.paddr;
                res_fault <= nxt.fault;
                res_hi    <= nxt.hi;
                res_lo    <= nxt.lo;
            end
        end
    end

endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk
    import tlb_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            lk_user,
    input logic            lk_write,
    input logic [1:0]      cfg_mode,
    input logic            res_valid,
    input logic            res_hit,
    input logic [VA_W-1:0] res_paddr,
    input logic [2:0]      res_fault,
    input logic [VA_W-1:0] res_hi,
    input logic [VA_W-1:0] res_lo
);

    // R12
    res_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (res_valid == $past(lk_valid)));

    // R10
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && cfg_mode == 2'b00) |=>
            (!res_hit && res_fault == 3'(FLT_NONE) && res_paddr == $past(lk_vaddr)));

    // R6
    page_offset_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (res_fault != 3'(FLT_NONE) ||
                      res_paddr[PAGE_SHIFT-1:0] == $past(lk_vaddr[PAGE_SHIFT-1:0])));

    // R8
    kern_user_only_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_user) |=> (res_fault != 3'(FLT_KERNEL)));

    // R9
    wprot_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_write) |=> (res_fault != 3'(FLT_WPROT)));

    // R11
    miss_words_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_hi == '0 && res_lo == '0));

    // R4
    hit_not_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_hit) |-> (res_fault != 3'(FLT_MISS)));

endmodule

bind tlb_lookup_top tlb_lookup_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_vaddr  (lk_vaddr),
    .lk_user   (lk_user),
    .lk_write  (lk_write),
    .cfg_mode  (cfg_mode),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_paddr (res_paddr),
    .res_fault (res_fault),
    .res_hi    (res_hi),
    .res_lo    (res_lo)
);

// File: tb/tlb_lookup_top_tb_top.sv
module tlb_lookup_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_way;
    logic [3:0]  wr_idx;
    logic [31:0] wr_hi, wr_lo;
    logic        lk_valid;
    logic [31:0] lk_vaddr;
    logic [7:0]  lk_pid;
    logic        lk_user, lk_write;
    logic [1:0]  cfg_mode;
    logic        cfg_kguard;
    logic        res_valid, res_hit;
    logic [1:0]  res_way;
    logic [31:0] res_paddr;
    logic [2:0]  res_fault;
    logic [31:0] res_hi, res_lo;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [31:0] m_hi [4][16];
    logic [31:0] m_lo [4][16];

    typedef struct packed {
        logic        hit;
        logic [1:0]  way;
        logic [31:0] paddr;
        logic [2:0]  fault;
        logic [31:0] hi;
        logic [31:0] lo;
    } exp_t;

    always #4 clk = ~clk;

    tlb_lookup_top dut_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
        .lk_user(lk_user), .lk_write(lk_write),
        .cfg_mode(cfg_mode), .cfg_kguard(cfg_kguard),
        .res_valid(res_valid), .res_hit(res_hit), .res_way(res_way),
        .res_paddr(res_paddr), .res_fault(res_fault), .res_hi(res_hi), .res_lo(res_lo)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            fails = fails + 1;
            $display("FAIL R12 watchdog expired: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [31:0] mk_hi(input logic [18:0] vpn, input logic [7:0] pid);
        return {vpn, 5'b0, pid};
    endfunction

    function automatic logic [31:0] mk_lo(input logic [18:0] pfn, input logic g,
                                          input logic v, input logic k, input logic w);
        return {pfn, 8'b0, g, v, k, w, 1'b0};
    endfunction

    function automatic exp_t predict(input logic [31:0] va, input logic [7:0] pid,
                                     input logic user, input logic wr,
                                     input logic [1:0] mode, input logic kg);
        exp_t e;
        logic [3:0] row;
        e = '0;
        if (mode == 2'b00) begin
            e.paddr = va;
            return e;
        end
        row = va[16:13];
        for (int w = 3; w >= 0; w--) begin
            if (m_hi[w][row][31:13] == va[31:13] &&
                (m_lo[w][row][4] || m_hi[w][row][7:0] == pid)) begin
                e.hit = 1'b1;
                e.way = 2'(w);
                e.hi  = m_hi[w][row];
                e.lo  = m_lo[w][row];
            end
        end
        if (!e.hit) begin
            e.fault = 3'd1;
        end else begin
            if (!e.lo[3])                  e.fault = 3'd2;
            else if (kg && e.lo[2] && user) e.fault = 3'd3;
            else if (wr && !e.lo[1])        e.fault = 3'd4;
            else                            e.fault = 3'd0;
            if (e.fault == 3'd0) e.paddr = {e.lo[31:13], va[12:0]};
        end
        return e;
    endfunction

    task automatic load(input logic [1:0] w, input logic [3:0] i,
                        input logic [31:0] hi, input logic [31:0] lo);
        @(negedge clk);
        wr_en = 1'b1; wr_way = w; wr_idx = i; wr_hi = hi; wr_lo = lo;
        @(negedge clk);
        wr_en = 1'b0;
        m_hi[w][i] = hi;
        m_lo[w][i] = lo;
    endtask

    task automatic compare(input string tag, input exp_t e);
        exp_t a;
        a = {res_hit, res_way, res_paddr, res_fault, res_hi, res_lo};
        checks = checks + 1;
        if (!res_valid || a != e) begin
            fails = fails + 1;
            $display("FAIL %s: actual v=%0b hit=%0b way=%0d pa=%h flt=%0d hi=%h lo=%h expected v=1 hit=%0b way=%0d pa=%h flt=%0d hi=%h lo=%h",
                     tag, res_valid, a.hit, a.way, a.paddr, a.fault, a.hi, a.lo,
                     e.hit, e.way, e.paddr, e.fault, e.hi, e.lo);
        end
    endtask

    task automatic lookup(input string tag, input logic [31:0] va, input logic [7:0] pid,
                          input logic user, input logic wr,
                          input logic [1:0] mode, input logic kg);
        exp_t e;
        e = predict(va, pid, user, wr, mode, kg);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_pid = pid;
        lk_user = user; lk_write = wr; cfg_mode = mode; cfg_kguard = kg;
        @(negedge clk);
        lk_valid = 1'b0;
        compare(tag, e);
    endtask

    task automatic check_bit(input string tag, input logic act, input logic expv);
        checks = checks + 1;
        if (act !== expv) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, expv);
        end
    endtask

    localparam logic [18:0] VP_A = 19'h12345;   // row 5
    localparam logic [18:0] VP_B = 19'h0ABC7;   // row 7
    localparam logic [18:0] VP_C = 19'h00AB9;   // row 9

    initial begin
        exp_t e;
        void'($urandom(32'd20240611));
        for (int w = 0; w < 4; w++)
            for (int i = 0; i < 16; i++) begin
                m_hi[w][i] = '0;
                m_lo[w][i] = '0;
            end
        rst = 1'b1; wr_en = 0; wr_way = 0; wr_idx = 0; wr_hi = 0; wr_lo = 0;
        lk_valid = 0; lk_vaddr = 0; lk_pid = 0; lk_user = 0; lk_write = 0;
        cfg_mode = 2'b01; cfg_kguard = 0;
        repeat (3) @(negedge clk);
        check_bit("R1 res_valid in reset", res_valid, 1'b0);
        check_bit("R1 res_fault zero in reset", res_fault == 3'd0, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R12 res_valid idle after reset", res_valid, 1'b0);

        lookup("R1 cleared entries miss", {19'h00001, 13'h0123}, 8'd5, 0, 0, 2'b01, 0);

        // R2 R6 basic hit in way 2
        load(2'd2, 4'd5, mk_hi(VP_A, 8'd7), mk_lo(19'h7F00F, 0, 1, 0, 1));
        lookup("R2/R6 hit way2", {VP_A, 13'h1ABC}, 8'd7, 1, 1, 2'b10, 1);
        // R4 tag mismatch
        lookup("R4 pid mismatch misses", {VP_A, 13'h0004}, 8'd8, 0, 0, 2'b01, 0);
        // R3 row right, page differs in upper bits
        lookup("R3 upper vpn differs", {VP_A ^ 19'h40000, 13'h0}, 8'd7, 0, 0, 2'b01, 0);
        // R4 shared entry matches any tag
        load(2'd0, 4'd7, mk_hi(VP_B, 8'd1), mk_lo(19'h00123, 1, 1, 0, 1));
        lookup("R4 shared hit other pid", {VP_B, 13'h1FFF}, 8'd200, 0, 0, 2'b11, 0);
        // R5 duplicates in way 1 and 3
        load(2'd3, 4'd5, mk_hi(VP_A, 8'd9), mk_lo(19'h33333, 0, 1, 0, 1));
        load(2'd1, 4'd5, mk_hi(VP_A, 8'd9), mk_lo(19'h11111, 0, 1, 0, 1));
        lookup("R5 lowest way wins", {VP_A, 13'h0055}, 8'd9, 0, 0, 2'b01, 0);
        // R7 absent
        load(2'd1, 4'd5, mk_hi(VP_A, 8'd9), mk_lo(19'h11111, 0, 0, 1, 0));
        lookup("R7 absent entry", {VP_A, 13'h0055}, 8'd9, 1, 1, 2'b01, 1);
        // R8 supervisor-only
        load(2'd0, 4'd7, mk_hi(VP_B, 8'd1), mk_lo(19'h00123, 1, 1, 1, 0));
        lookup("R8 kern guard user", {VP_B, 13'h0010}, 8'd1, 1, 1, 2'b01, 1);
        lookup("R8 guard disabled", {VP_B, 13'h0010}, 8'd1, 1, 0, 2'b01, 0);
        lookup("R8 supervisor access", {VP_B, 13'h0010}, 8'd1, 0, 0, 2'b01, 1);
        // R9 write-protect
        lookup("R9 write to readonly", {VP_B, 13'h0010}, 8'd1, 0, 1, 2'b01, 1);
        lookup("R9 read of readonly", {VP_B, 13'h0010}, 8'd1, 0, 0, 2'b01, 1);
        lookup("R9/R8 kern over wprot", {VP_B, 13'h0010}, 8'd1, 1, 1, 2'b01, 1);
        // R10 passthrough
        lookup("R10 passthrough", {VP_B, 13'h0777}, 8'd1, 1, 1, 2'b00, 1);
        // R11 faulted hit still reports words
        lookup("R11 words on faulted hit", {VP_A, 13'h0}, 8'd9, 0, 0, 2'b10, 0);

        // R2 same-cycle write and lookup
        e = predict({VP_C, 13'h0042}, 8'd1, 0, 0, 2'b01, 0);
        @(negedge clk);
        wr_en = 1; wr_way = 2'd0; wr_idx = 4'd9;
        wr_hi = mk_hi(VP_C, 8'd3); wr_lo = mk_lo(19'h04444, 1, 1, 0, 1);
        lk_valid = 1; lk_vaddr = {VP_C, 13'h0042}; lk_pid = 8'd1;
        lk_user = 0; lk_write = 0; cfg_mode = 2'b01; cfg_kguard = 0;
        @(negedge clk);
        wr_en = 0; lk_valid = 0;
        m_hi[0][9] = mk_hi(VP_C, 8'd3);
        m_lo[0][9] = mk_lo(19'h04444, 1, 1, 0, 1);
        compare("R2 same-cycle lookup sees old", e);
        lookup("R2 next lookup sees new", {VP_C, 13'h0042}, 8'd1, 0, 0, 2'b01, 0);
        @(negedge clk);
        check_bit("R12 res_valid drops", res_valid, 1'b0);
        check_bit("R12 result held", res_paddr == {19'h04444, 13'h0042}, 1'b1);

        // random entries: small page pool per row so ways collide
        for (int n = 0; n < 96; n++) begin
            logic [3:0] i;
            logic [1:0] w;
            i = 4'($urandom % 16);
            w = 2'($urandom % 4);
            load(w, i,
                 mk_hi({15'($urandom % 3), i}, 8'($urandom % 4)),
                 mk_lo(19'($urandom), ($urandom % 4) == 0, ($urandom % 6) != 0,
                       1'($urandom), 1'($urandom)));
        end
        for (int n = 0; n < 400; n++) begin
            logic [18:0] vpn;
            if (($urandom % 4) != 0)
                vpn = m_hi[$urandom % 4][$urandom % 16][31:13];
            else
                vpn = {15'($urandom % 3), 4'($urandom)};
            lookup("R3/R4/R5/R6/R7/R8/R9/R10/R11 random", {vpn, 13'($urandom)},
                   8'($urandom % 4), 1'($urandom), 1'($urandom),
                   2'($urandom), 1'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule